// File: doc/BRIEF.md
# Serial audio-link frame receiver

This block deserializes the line that carries data from an audio codec back to its controller. It runs on the codec bit clock and samples both the serial data and the frame sync on the falling edge of that clock, because the codec changes them on the rising edge. A frame starts when sync rises. The block then shifts in 256 bits, most significant bit first: a 16-bit tag slot followed by twelve 20-bit slots.

When a frame is complete, the block presents the tag and all twelve slots in parallel. It also presents the frame-valid flag and the per-slot valid flags decoded from the tag, and pulses a one-cycle ready strobe. Audio slots normally carry an 18-bit two's-complement sample, left-justified, with the two lowest bits zero. Slot 1 and slot 2 carry register-access fields. The block passes every slot through untouched.

If sync rises in the middle of a frame, the block drops the partial frame, restarts from that edge and raises a sticky framing-error flag.

Top module: `audio_frame_rx`

## Requirements
- R1: While `rst` is high at a falling bit-clock edge, the block clears `tag`, `slot_data`, `frame_valid`, `slot_valid`, `frame_rdy` and `frame_err` to zero.
- R2: Serial data that arrives before sync rises for the first time after reset is ignored. No strobe occurs and the outputs stay zero.
- R3: The falling edge that first samples `sync_in` high (after a low sample) captures bit 0 of a frame. Bits 0 to 15 form `tag`, with bit 0 as `tag[15]`. Bits 16+20k to 35+20k form slot k+1, which appears on `slot_data[k]` with its first bit in bit 19.
- R4: The outputs update and `frame_rdy` goes high at the falling edge that follows the capture of bit 255. `frame_rdy` stays high for exactly one bit-clock cycle.
- R5: `frame_valid` equals `tag[15]`. `slot_valid[k]` equals `tag[14-k]`, for k from 0 to 11. A tag of 0xF800 gives slot_valid 0x00F, 0x9800 gives 0x00C, and 0xFFF8 gives 0xFFF.
- R6: Frames sent back to back, each starting with a new sync rise, are each captured and each produce their own strobe.
- R7: A sync rise after 1 to 255 bits of a frame have been captured discards that partial frame with no strobe. It sets `frame_err` and starts a new frame at that edge, and this new frame is captured normally.
- R8: `frame_err` stays set until reset.
- R9: Between strobes, `tag`, `slot_data` and the valid flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Codec bit clock; all state updates on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| sync_in | input | 1 | Frame sync from the codec, high during the tag slot |
| sdata_in | input | 1 | Serial data from the codec |
| tag | output | 16 | Tag slot of the last complete frame |
| slot_data | output | 240 | Twelve 20-bit slots; element k holds slot k+1 |
| frame_valid | output | 1 | Frame-valid flag taken from the tag |
| slot_valid | output | 12 | Per-slot valid flags; bit k belongs to slot k+1 |
| frame_rdy | output | 1 | One-cycle strobe when new frame outputs appear |
| frame_err | output | 1 | Sticky flag for a sync rise in the middle of a frame |

## Verification
The assertions take for granted that sync and data are stable around each falling edge of the bit clock. They also assume that a frame is marked only by a clean low-to-high sync transition, and that reset is held for at least two edges. The bench changes every input just after the rising edge and holds sync low between frames. It pulses sync high for the 16 tag bits and raises sync mid-frame only in the deliberate early-sync scenario. Output changes are read at the following rising edge, half a period after the falling edge that produced them.

// File: rtl/audio_frame_rx.sv
module audio_frame_rx #(
  parameter int TAG_W  = 16,
  parameter int SLOT_W = 20,
  parameter int NSLOT  = 12
) (
  input  logic                         bclk,
  input  logic                         rst,
  input  logic                         sync_in,
  input  logic                         sdata_in,
  output logic [TAG_W-1:0]             tag,
  output logic [NSLOT-1:0][SLOT_W-1:0] slot_data,
  output logic                         frame_valid,
  output logic [NSLOT-1:0]             slot_valid,
  output logic                         frame_rdy,
  output logic                         frame_err
);
  localparam int FRAME_BITS = TAG_W + NSLOT * SLOT_W;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic                  sync_q;
  logic                  done;
  logic [CNT_W-1:0]      cnt;
  logic [FRAME_BITS-1:0] shreg;
  logic [FRAME_BITS-1:0] frame_q;
  logic                  rise;

  assign rise = sync_in & ~sync_q;

  always_ff @(negedge bclk) begin
    if (rst) begin
      sync_q    <= 1'b0;
      cnt       <= '0;
      shreg     <= '0;
      done      <= 1'b0;
      frame_q   <= '0;
      frame_rdy <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      sync_q    <= sync_in;
      frame_rdy <= done;
      done      <= 1'b0;
      if (done) frame_q <= shreg;
      if (rise) begin
        if (cnt != '0) frame_err <= 1'b1;
        shreg <= {shreg[FRAME_BITS-2:0], sdata_in};
        cnt   <= CNT_W'(1);
      end else if (cnt != '0) begin
        shreg <= {shreg[FRAME_BITS-2:0], sdata_in};
        if (cnt == LAST) begin
          cnt  <= '0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign tag         = frame_q[FRAME_BITS-1 -: TAG_W];
  assign frame_valid = tag[TAG_W-1];

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    assign slot_data[k]  = frame_q[FRAME_BITS-TAG_W-1-k*SLOT_W -: SLOT_W];
    assign slot_valid[k] = tag[TAG_W-2-k];
  end

  a_r4_strobe_one_cycle: assert property (@(negedge bclk) disable iff (rst)
    frame_rdy |=> !frame_rdy);

  a_r8_err_sticky: assert property (@(negedge bclk) disable iff (rst)
    frame_err |=> frame_err);

  a_r9_hold_between_strobes: assert property (@(negedge bclk) disable iff (rst)
    !frame_rdy |-> $stable(frame_q));

  a_r7_err_needs_sync: assert property (@(negedge bclk) disable iff (rst)
    $rose(frame_err) |-> $past(sync_in));
endmodule

// File: tb/audio_frame_rx_tb.sv
module audio_frame_rx_tb;
  logic bclk = 1'b0;
  logic rst = 1'b1;
  logic sync_in = 1'b0;
  logic sdata_in = 1'b0;
  logic [15:0] tag;
  logic [11:0][19:0] slot_data;
  logic frame_valid;
  logic [11:0] slot_valid;
  logic frame_rdy;
  logic frame_err;

  audio_frame_rx u_dut (
    .bclk(bclk), .rst(rst), .sync_in(sync_in), .sdata_in(sdata_in),
    .tag(tag), .slot_data(slot_data), .frame_valid(frame_valid),
    .slot_valid(slot_valid), .frame_rdy(frame_rdy), .frame_err(frame_err)
  );

  always #4 bclk = ~bclk;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  int ncap = 0;
  int run = 0;
  int maxrun = 0;
  logic [15:0]       cap_tag   [8];
  logic [11:0][19:0] cap_slots [8];
  logic              cap_fv    [8];
  logic [11:0]       cap_sv    [8];

  always @(posedge bclk) begin
    if (rst) begin
      run = 0;
    end else if (frame_rdy) begin
      if (ncap < 8) begin
        cap_tag[ncap]   = tag;
        cap_slots[ncap] = slot_data;
        cap_fv[ncap]    = frame_valid;
        cap_sv[ncap]    = slot_valid;
      end
      ncap++;
      run++;
      if (run > maxrun) maxrun = run;
    end else begin
      run = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] pat(input int seed, input int k);
    return 20'((seed * 32'h1F3 + k * 32'h2A5D) ^ 32'hA5A5A);
  endfunction

  function automatic logic [11:0] dec_valid(input logic [15:0] t);
    logic [11:0] v;
    for (int k = 0; k < 12; k++) v[k] = t[14-k];
    return v;
  endfunction

  task automatic drive_bits(input logic [15:0] t, input int seed, input int nbits);
    logic [255:0] f;
    f[255:240] = t;
    for (int k = 0; k < 12; k++) f[239-20*k -: 20] = pat(seed, k);
    for (int b = 0; b < nbits; b++) begin
      @(posedge bclk);
      sync_in  <= (b < 16);
      sdata_in <= f[255-b];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge bclk);
      sync_in  <= 1'b0;
      sdata_in <= 1'b0;
    end
  endtask

  task automatic check_cap(input int idx, input logic [15:0] t, input int seed, input string req);
    logic [11:0][19:0] es;
    for (int k = 0; k < 12; k++) es[k] = pat(seed, k);
    chk(cap_tag[idx] == t, {req, " tag"}, 256'(cap_tag[idx]), 256'(t));
    chk(cap_slots[idx] == es, {req, " slots"}, 256'(cap_slots[idx]), 256'(es));
    chk(cap_fv[idx] == t[15], "R5 frame_valid", 256'(cap_fv[idx]), 256'(t[15]));
    chk(cap_sv[idx] == dec_valid(t), "R5 slot_valid", 256'(cap_sv[idx]), 256'(dec_valid(t)));
  endtask

  task automatic do_reset();
    @(posedge bclk);
    rst <= 1'b1; sync_in <= 1'b0; sdata_in <= 1'b0;
    repeat (3) @(posedge bclk);
    chk(tag == 0 && slot_data == '0, "R1 data cleared", 256'({tag, slot_data}), 256'(0));
    chk(frame_rdy == 0 && frame_err == 0 && frame_valid == 0 && slot_valid == 0,
        "R1 flags cleared", 256'({frame_rdy, frame_err, frame_valid, slot_valid}), 256'(0));
    rst <= 1'b0;
  endtask

  task automatic t_ignore();
    for (int i = 0; i < 600; i++) begin
      @(posedge bclk);
      sync_in  <= 1'b0;
      sdata_in <= i[0] ^ i[3];
    end
    idle(2);
    chk(ncap == 0, "R2 no strobe before sync", 256'(ncap), 256'(0));
    chk(tag == 0 && slot_data == '0, "R2 outputs unchanged", 256'({tag, slot_data}), 256'(0));
  endtask

  task automatic t_single();
    int base = ncap;
    drive_bits(16'hF800, 1, 256);
    @(posedge bclk); sync_in <= 1'b0; sdata_in <= 1'b0;
    chk(frame_rdy == 0, "R4 strobe not early", 256'(frame_rdy), 256'(0));
    @(posedge bclk);
    chk(frame_rdy == 1, "R4 strobe after bit 255", 256'(frame_rdy), 256'(1));
    @(posedge bclk);
    chk(frame_rdy == 0, "R4 strobe ends", 256'(frame_rdy), 256'(0));
    chk(ncap == base + 1, "R4 one strobe", 256'(ncap), 256'(base + 1));
    check_cap(base, 16'hF800, 1, "R3");
    chk(slot_valid == 12'h00F, "R5 F800 decode", 256'(slot_valid), 256'(12'h00F));
  endtask

  task automatic t_b2b();
    int base = ncap;
    drive_bits(16'h9800, 2, 256);
    drive_bits(16'hFFF8, 3, 256);
    idle(4);
    chk(ncap == base + 2, "R6 two strobes", 256'(ncap), 256'(base + 2));
    check_cap(base, 16'h9800, 2, "R6 first");
    check_cap(base + 1, 16'hFFF8, 3, "R6 second");
    chk(cap_sv[base] == 12'h00C, "R5 9800 decode", 256'(cap_sv[base]), 256'(12'h00C));
    idle(60);
    chk(tag == 16'hFFF8 && slot_valid == 12'hFFF, "R9 hold after strobe",
        256'({tag, slot_valid}), 256'({16'hFFF8, 12'hFFF}));
    chk(slot_data[11] == pat(3, 11), "R9 slot hold", 256'(slot_data[11]), 256'(pat(3, 11)));
  endtask

  task automatic t_early();
    int base = ncap;
    chk(frame_err == 0, "R7 no error yet", 256'(frame_err), 256'(0));
    drive_bits(16'hC000, 4, 100);
    drive_bits(16'h8000, 5, 256);
    idle(4);
    chk(ncap == base + 1, "R7 partial frame dropped", 256'(ncap), 256'(base + 1));
    check_cap(base, 16'h8000, 5, "R7 resync frame");
    chk(frame_err == 1, "R7 error flagged", 256'(frame_err), 256'(1));
    drive_bits(16'hA000, 6, 256);
    idle(4);
    chk(frame_err == 1, "R8 error sticky", 256'(frame_err), 256'(1));
    check_cap(base + 1, 16'hA000, 6, "R8 later frame");
  endtask

  initial begin
    repeat (150000) @(posedge bclk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_ignore();
    t_single();
    t_b2b();
    t_early();
    do_reset();
    chk(frame_err == 0, "R8 reset clears error", 256'(frame_err), 256'(0));
    chk(maxrun == 1, "R4 strobe width", 256'(maxrun), 256'(1));
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule